// File: doc/BRIEF.md
# Non-Restoring Iterative Divider

This unit divides a positive 32-bit dividend by a signed 16-bit divisor and produces one quotient bit per clock using the non-restoring method. Partial remainder and quotient bits share a single 36-bit accumulator. The upper 20 bits hold the partial remainder, which is a 4-bit extension plus the high word. The low 16 bits gradually fill with quotient bits, which are shifted in through a carry flag.

The client pulses `start` with the dividend, the divisor and a step count N, where 2 ≤ N ≤ 16. On that edge the unit loads the dividend sign-extended to 36 bits and clears the carry. It then performs exactly N steps.

In each step the unit:
- takes the XOR of accumulator bit 35 and divisor bit 15;
- shifts the whole accumulator left and inserts the old carry at bit 0;
- subtracts the sign-extended divisor from the upper 20 bits when the XOR was 0, or adds it when the XOR was 1;
- sets the new carry to the inverse of the new bit 35.

When the steps are finished, `done` pulses for one cycle. At that point the unit presents the raw accumulator and the final carry, a signed quotient, a corrected remainder and an `invalid` flag. All results hold until the next accepted start.

The FSM has three states:
- `ST_IDLE`: waiting.
- `ST_STEP`: iterating.
- `ST_DONE`: result pulse.

It has four transitions:
- `T_LAUNCH`: `ST_IDLE` to `ST_STEP` on start.
- `T_ITER`: stays in `ST_STEP` while more than one step remains.
- `T_FINISH`: `ST_STEP` to `ST_DONE` on the last step.
- `T_RETIRE`: `ST_DONE` back to `ST_IDLE`.

Top module: `nr_div_unit`

## Requirements
- R1: After reset the unit is idle, with `busy` and `done` both 0.
- R2: A start is taken only in idle. `busy` reads 1 from the cycle after the start edge through the `done` cycle.
- R3: Exactly N step edges follow the start edge. `done` is therefore first high N+1 clock edges after the start edge, and it lasts exactly one cycle.
- R4: Each step shifts the accumulator left by one and places the previous carry in bit 0. The arithmetic leaves the low 16 bits unchanged, so new bits 15:1 equal old bits 14:0.
- R5: The add/subtract is chosen by XOR(acc[35], divisor[15]): add on 1, subtract on 0. The carry after a step is 1 exactly when the new partial remainder is non-negative. The carry is 0 at start.
- R6: With Q = floor(X·2^N / (|d|·2^16)), `quotient` (17-bit two's complement) equals Q when the divisor is non-negative and −Q when it is negative.
- R7: `remainder` (36 bits) equals X·2^N − Q·|d|·2^16. The unit obtains it by adding |d| to the upper 20 bits when they are negative and by clearing the low N bits.
- R8: At `done`, `acc_out[15:0]` equals ((X·2^N) mod 2^16) + floor(Q/2), and `carry_out` equals Q mod 2. The upper 20 bits hold R7's high part when `carry_out` is 1, and that value minus |d| when it is 0.
- R9: `invalid` is 1 when any of the following holds: the divisor is zero, X ≥ |d|·2^16, or N < 2 or N > 16. An out-of-range N runs 16 steps.
- R10: A start pulse while busy is ignored, and the results of the running division are unaffected.
- R11: In idle without a start, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a division (idle only) |
| dividend | input | 32 | Positive dividend X |
| divisor | input | 16 | Signed divisor d |
| steps | input | 5 | Step count N |
| busy | output | 1 | Division in progress or result pulse |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Operands or count outside the valid range |
| acc_out | output | 36 | Raw accumulator |
| carry_out | output | 1 | Final carry (last quotient bit) |
| quotient | output | 17 | Signed corrected quotient |
| remainder | output | 36 | True remainder |

## Verification
On every cycle, the assertions check the following:
- the one-cycle `done` pulse and the `busy` window;
- the shift of the low word with the carry inserted at bit 0;
- that the latched divisor and count are frozen while busy;
- that the results are held in idle;
- the sign of the quotient against the divisor;
- the range of the remainder.

The quotient magnitude, the exact remainder, the raw accumulator pattern, the step latency, rejection of a mid-run start and the `invalid` cases need known operands. Only the bench's sweep can show them; it compares them with arithmetic values computed over many divisor, dividend and count combinations.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } nrdiv_state_t;
endpackage

// File: rtl/nrdiv_guard.sv
module nrdiv_guard #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 5
) (
    input  logic [2*DIV_W-1:0] dividend,
    input  logic [DIV_W-1:0]   divisor,
    input  logic [CNT_W-1:0]   steps,
    output logic               bad,
    output logic [CNT_W-1:0]   eff_steps
);
    logic [DIV_W:0]   mag;
    logic [2*DIV_W:0] limit;
    logic             bad_cnt;

    always_comb begin
        mag     = divisor[DIV_W-1] ? (~{1'b1, divisor} + 1'b1) : {1'b0, divisor};
        limit   = {mag, {DIV_W{1'b0}}};
        bad_cnt = (steps < CNT_W'(2)) || (steps > CNT_W'(DIV_W));
        bad     = (divisor == '0) || ({1'b0, dividend} >= limit) || bad_cnt;
        eff_steps = bad_cnt ? CNT_W'(DIV_W) : steps;
    end
endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int DIV_W = 16,
    parameter int ACC_W = 36
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic             carry_in,
    input  logic [DIV_W-1:0] div,
    output logic [ACC_W-1:0] acc_nx,
    output logic             carry_nx
);
    localparam int HI_W = ACC_W - DIV_W;

    logic             do_sub;
    logic [ACC_W-1:0] shifted;
    logic [HI_W-1:0]  dext;
    logic [HI_W-1:0]  hi_new;

    always_comb begin
        // sign compare taken before the shift
        do_sub  = ~(acc_in[ACC_W-1] ^ div[DIV_W-1]);
        shifted = {acc_in[ACC_W-2:0], carry_in};
        dext    = {{(HI_W-DIV_W){div[DIV_W-1]}}, div};
        hi_new  = do_sub ? (shifted[ACC_W-1:DIV_W] - dext)
                         : (shifted[ACC_W-1:DIV_W] + dext);
        acc_nx   = {hi_new, shifted[DIV_W-1:0]};
        carry_nx = ~hi_new[HI_W-1];
    end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int DIV_W = 16,
    parameter int ACC_W = 36,
    parameter int CNT_W = 5
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             carry,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] nsteps,
    output logic [DIV_W:0]   quotient,
    output logic [ACC_W-1:0] remainder
);
    localparam int HI_W = ACC_W - DIV_W;

    logic [DIV_W:0]  qmask;
    logic [DIV_W:0]  qraw;
    logic [DIV_W:0]  qmag;
    logic [HI_W-1:0] dext;
    logic [HI_W-1:0] dmag;
    logic [HI_W-1:0] hi_fix;

    always_comb begin
        qmask = ({{DIV_W{1'b0}}, 1'b1} << nsteps) - 1'b1;
        qraw  = ({1'b0, acc[DIV_W-1:0]} << 1) | {{DIV_W{1'b0}}, carry};
        qmag  = qraw & qmask;
        quotient = div[DIV_W-1] ? ((DIV_W+1)'(0) - qmag) : qmag;

        dext   = {{(HI_W-DIV_W){div[DIV_W-1]}}, div};
        dmag   = div[DIV_W-1] ? (HI_W'(0) - dext) : dext;
        hi_fix = acc[ACC_W-1] ? (acc[ACC_W-1:DIV_W] + dmag) : acc[ACC_W-1:DIV_W];
        remainder = {hi_fix, acc[DIV_W-1:0] & ~qmask[DIV_W-1:0]};
    end
endmodule

// File: rtl/nr_div_unit.sv
module nr_div_unit
    import nrdiv_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int EXT_W = 4,
    localparam int ACC_W = EXT_W + 2*DIV_W,
    localparam int CNT_W = $clog2(DIV_W+1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2*DIV_W-1:0] dividend,
    input  logic [DIV_W-1:0]   divisor,
    input  logic [CNT_W-1:0]   steps,
    output logic               busy,
    output logic               done,
    output logic               invalid,
    output logic [ACC_W-1:0]   acc_out,
    output logic               carry_out,
    output logic [DIV_W:0]     quotient,
    output logic [ACC_W-1:0]   remainder
);
    nrdiv_state_t     state_q, state_d;
    logic [ACC_W-1:0] acc_q;
    logic             carry_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nsteps_q;
    logic             inval_q;

    logic             launch;
    logic             g_bad;
    logic [CNT_W-1:0] g_steps;
    logic [ACC_W-1:0] acc_nx;
    logic             carry_nx;

    nrdiv_guard #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_guard (
        .dividend (dividend),
        .divisor  (divisor),
        .steps    (steps),
        .bad      (g_bad),
        .eff_steps(g_steps)
    );

    nrdiv_step #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u_step (
        .acc_in  (acc_q),
        .carry_in(carry_q),
        .div     (div_q),
        .acc_nx  (acc_nx),
        .carry_nx(carry_nx)
    );

    nrdiv_fix #(.DIV_W(DIV_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_fix (
        .acc      (acc_q),
        .carry    (carry_q),
        .div      (div_q),
        .nsteps   (nsteps_q),
        .quotient (quotient),
        .remainder(remainder)
    );

    assign launch = start && (state_q == ST_IDLE);

    // next-state logic: T_LAUNCH, T_ITER, T_FINISH, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)               state_d = ST_STEP;
            ST_STEP: if (cnt_q == CNT_W'(1))  state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            carry_q  <= 1'b0;
            div_q    <= '0;
            cnt_q    <= '0;
            nsteps_q <= '0;
            inval_q  <= 1'b0;
        end else if (launch) begin
            acc_q    <= {{EXT_W{dividend[2*DIV_W-1]}}, dividend};
            carry_q  <= 1'b0;
            div_q    <= divisor;
            cnt_q    <= g_steps;
            nsteps_q <= g_steps;
            inval_q  <= g_bad;
        end else if (state_q == ST_STEP) begin
            acc_q   <= acc_nx;
            carry_q <= carry_nx;
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        invalid   = inval_q;
        acc_out   = acc_q;
        carry_out = carry_q;
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_shift_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (acc_q[DIV_W-1:1] == $past(acc_q[DIV_W-2:0]))
                                 && (acc_q[0] == $past(carry_q)));
    p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(div_q) && $stable(nsteps_q) && $stable(inval_q)));
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(acc_out)));
    p_qsign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid && (quotient != '0)) |-> (quotient[DIV_W] == div_q[DIV_W-1]));
    p_rem_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid) |-> (remainder[ACC_W-1:2*DIV_W-1] == '0));
endmodule

// File: tb/sim_nr_div_unit.sv
module sim_nr_div_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [4:0]  steps = '0;
    logic        busy, done, invalid, carry_out;
    logic [35:0] acc_out, remainder;
    logic [16:0] quotient;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nr_div_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .steps(steps), .busy(busy), .done(done),
        .invalid(invalid), .acc_out(acc_out), .carry_out(carry_out),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_op(input longint x, input longint d, input int n, input bit poke,
                          output int cyc);
        @(negedge clk);
        dividend = x[31:0]; divisor = d[15:0]; steps = n[4:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        while (!done && cyc < 64) begin
            if (poke && cyc == 2) begin
                start = 1'b1; dividend = 32'h0123_4567; divisor = 16'h0003; steps = 5'd3;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    task automatic check_valid(input longint x, input longint d, input int n, input bit poke);
        longint ad, dm, xs, q, rf, rhi, ufin, accx, qexp;
        int cyc;
        run_op(x, d, n, poke, cyc);
        ad = (d < 0) ? -d : d;
        dm = ad <<< 16;
        xs = x <<< n;
        q  = xs / dm;
        rf = xs - q * dm;
        rhi = rf >>> 16;
        ufin = ((q & 1) != 0) ? rhi : rhi - ad;
        accx = ((ufin & 64'hFFFFF) <<< 16) | ((xs & 64'hFFFF) | (q >>> 1));
        qexp = (d < 0) ? -q : q;
        chk(cyc == n + 1, "R3 latency", cyc, n + 1);
        chk(done == 1'b1, "R3 done seen", longint'(done), 1);
        chk(invalid == 1'b0, "R9 valid operands", longint'(invalid), 0);
        chk(longint'($signed(quotient)) == qexp, "R6 quotient", longint'($signed(quotient)), qexp);
        chk(longint'(remainder) == rf, "R7 remainder", longint'(remainder), rf);
        chk(longint'(acc_out) == accx, "R8 R4 R5 raw accumulator", longint'(acc_out), accx);
        chk(longint'(carry_out) == (q & 1), "R8 carry", longint'(carry_out), q & 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R3 one-cycle done", longint'(done), 0);
    endtask

    task automatic check_invalid(input longint x, input longint d, input int n, input int neff);
        int cyc;
        run_op(x, d, n, 1'b0, cyc);
        chk(invalid == 1'b1, "R9 invalid flag", longint'(invalid), 1);
        chk(cyc == neff + 1, "R9 latency with clamped count", cyc, neff + 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        longint dl[12] = '{1, 2, 3, 7, 255, 1000, 32767, -1, -2, -3, -1000, -32768};
        longint ad, lim, xv[6];
        longint q_hold, r_hold;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset idle", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", longint'(done), 0);

        for (int n = 2; n <= 16; n++) begin
            for (int k = 0; k < 12; k++) begin
                ad  = (dl[k] < 0) ? -dl[k] : dl[k];
                lim = ad <<< 16;
                xv[0] = 0; xv[1] = 1; xv[2] = lim - 1;
                xv[3] = lim / 3; xv[4] = lim / 2; xv[5] = (lim * 7) / 11 + 5;
                for (int j = 0; j < 6; j++)
                    check_valid(xv[j], dl[k], n, 1'b0);
            end
        end

        // R10: start pulses during a run are ignored
        check_valid(64'd123456789, 64'd4321, 16, 1'b1);
        check_valid(64'd5000000, -64'd777, 9, 1'b1);
        check_valid(64'd2, 64'd1, 2, 1'b1);

        // R9: invalid cases
        check_invalid(64'd1000, 64'd0, 8, 8);
        check_invalid(64'd7 <<< 16, 64'd7, 8, 8);
        check_invalid(64'd7 <<< 16, -64'd7, 12, 12);
        check_invalid(64'h7FFF_FFFF, 64'd100, 4, 4);
        check_invalid(64'd10, 64'd100, 0, 16);
        check_invalid(64'd10, 64'd100, 1, 16);
        check_invalid(64'd10, 64'd100, 17, 16);

        // R11: results hold in idle while inputs move without start
        check_valid(64'd987654, -64'd321, 11, 1'b0);
        q_hold = longint'($signed(quotient));
        r_hold = longint'(remainder);
        dividend = 32'h0000_0001; divisor = 16'h7FFF; steps = 5'd5;
        repeat (4) @(negedge clk);
        chk(longint'($signed(quotient)) == q_hold, "R11 quotient held",
            longint'($signed(quotient)), q_hold);
        chk(longint'(remainder) == r_hold, "R11 remainder held", longint'(remainder), r_hold);
        chk(busy == 1'b0, "R11 stays idle", longint'(busy), 0);

        report();
    end
endmodule